// File: doc/BRIEF.md
# Elapsed-Seconds to Hours, Minutes and Seconds Splitter

This block takes a binary count of seconds elapsed within one day and splits it into three binary fields: hours, minutes and seconds. It has no divider. Each division by sixty multiplies by a fixed reciprocal constant, 139811, and then shifts the product right by 23 bits. A multiply-and-subtract step then recovers the remainder.

Two divide-and-remainder stages are chained. The first stage splits the seconds input into total minutes and a seconds remainder. The second stage splits the total minutes into hours and a minutes remainder. The hours value is the quotient of the second stage and is not reduced any further.

The result can be taken straight from the logic or from an optional output register that a parameter selects. The default build registers it. The block is meant to sit between a free-running seconds counter and a decimal digit splitter.

Top module: `hms_split`

## Requirements
- R1: For every `secs_in` from 0 to 86399, the quotient of the first stage equals floor(`secs_in`/60). The quotient is formed as (`secs_in` × 139811) >> 23, and the product is kept at full width before the shift.
- R2: `seconds_o` equals `secs_in` mod 60. It is 6 bits wide and stays in the range 0..59.
- R3: `minutes_o` equals floor(`secs_in`/60) mod 60. It is 6 bits wide and stays in the range 0..59.
- R4: `hours_o` equals floor(`secs_in`/3600). It is 5 bits wide and stays in the range 0..23 for inputs up to 86399.
- R5: With the default `REG_OUT`=1, the outputs show the split of the `secs_in` value present at the previous rising edge of `clk`. They do not change between edges. With `REG_OUT`=0, the outputs follow `secs_in` without a clock.
- R6: While `rst_n` is low, the registered outputs read zero in every field, whatever `secs_in` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| secs_in | input | 17 | Seconds elapsed in the day, valid from 0 to 86399 |
| hours_o | output | 5 | Hours field, 0..23 |
| minutes_o | output | 6 | Minutes field, 0..59 |
| seconds_o | output | 6 | Seconds field, 0..59 |

## Verification
The assertions check the arithmetic identities on every cycle for any in-range input. Total minutes times sixty plus the seconds remainder rebuilds the input. Hours times sixty plus the minutes remainder rebuilds the total minutes. Both remainders stay below sixty. Two further assertions check that the output register copies the previous cycle's result and that reset clears it.

Only the bench's scenarios can show that the fields carry the right values for the right input. The bench sweeps all 86400 inputs, exercises the rollover points around 59/60 and 3599/3600, and checks the one-cycle delay of the output.

// File: rtl/hms_split_pkg.sv
package hms_split_pkg;

    localparam int unsigned SECS_W    = 17;
    localparam int unsigned HOURS_W   = 5;
    localparam int unsigned MINSEC_W  = 6;
    localparam int unsigned DIVISOR   = 60;
    localparam int unsigned RECIP     = 139811;
    localparam int unsigned SHIFT     = 23;
    localparam int unsigned DAY_SECS  = 86400;
    localparam int unsigned TOTMIN_W  = $clog2(DAY_SECS / DIVISOR);

    typedef struct packed {
        logic [HOURS_W-1:0]  hours;
        logic [MINSEC_W-1:0] minutes;
        logic [MINSEC_W-1:0] seconds;
    } hms_t;

endpackage

// File: rtl/recip_div.sv
// Quotient by constant: multiply by a scaled reciprocal, then shift right.
module recip_div #(
    parameter int unsigned IN_W    = 17,
    parameter int unsigned Q_W     = 11,
    parameter int unsigned RECIP   = 139811,
    parameter int unsigned SHIFT   = 23,
    parameter int unsigned CONST_W = $clog2(RECIP + 1)
) (
    input  logic [IN_W-1:0] num_i,
    output logic [Q_W-1:0]  quo_o
);
    localparam int unsigned PROD_W = IN_W + CONST_W;

    logic [PROD_W-1:0] prod;

    // Keep the full-width product so that no high bits drop before the shift.
    assign prod  = PROD_W'(num_i) * PROD_W'(RECIP);
    assign quo_o = Q_W'(prod >> SHIFT);
endmodule

// File: rtl/rem_stage.sv
// Remainder by multiply-subtract: num - quo * DIVISOR.
module rem_stage #(
    parameter int unsigned IN_W    = 17,
    parameter int unsigned Q_W     = 11,
    parameter int unsigned R_W     = 6,
    parameter int unsigned DIVISOR = 60
) (
    input  logic [IN_W-1:0] num_i,
    input  logic [Q_W-1:0]  quo_i,
    output logic [R_W-1:0]  rem_o
);
    assign rem_o = R_W'(num_i - IN_W'(quo_i) * IN_W'(DIVISOR));
endmodule

// File: rtl/hms_split.sv
module hms_split
    import hms_split_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SECS_W-1:0]   secs_in,
    output logic [HOURS_W-1:0]  hours_o,
    output logic [MINSEC_W-1:0] minutes_o,
    output logic [MINSEC_W-1:0] seconds_o
);
    logic [TOTMIN_W-1:0] tot_min;
    logic [MINSEC_W-1:0] sec_rem;
    logic [MINSEC_W-1:0] min_rem;
    logic [HOURS_W-1:0]  hrs;
    hms_t                out_d, out_q;

    // Stage one: seconds -> total minutes, seconds remainder
    recip_div #(.IN_W(SECS_W), .Q_W(TOTMIN_W), .RECIP(RECIP), .SHIFT(SHIFT))
        u_div_sec (.num_i(secs_in), .quo_o(tot_min));
    rem_stage #(.IN_W(SECS_W), .Q_W(TOTMIN_W), .R_W(MINSEC_W), .DIVISOR(DIVISOR))
        u_rem_sec (.num_i(secs_in), .quo_i(tot_min), .rem_o(sec_rem));

    // Stage two: total minutes -> hours, minutes remainder
    recip_div #(.IN_W(TOTMIN_W), .Q_W(HOURS_W), .RECIP(RECIP), .SHIFT(SHIFT))
        u_div_min (.num_i(tot_min), .quo_o(hrs));
    rem_stage #(.IN_W(TOTMIN_W), .Q_W(HOURS_W), .R_W(MINSEC_W), .DIVISOR(DIVISOR))
        u_rem_min (.num_i(tot_min), .quo_i(hrs), .rem_o(min_rem));

    always_comb begin
        out_d         = '0;
        out_d.hours   = hrs;
        out_d.minutes = min_rem;
        out_d.seconds = sec_rem;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    generate
        if (REG_OUT) begin : g_reg
            assign hours_o   = out_q.hours;
            assign minutes_o = out_q.minutes;
            assign seconds_o = out_q.seconds;

            // R5
            reg_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_q == $past(out_d)));

            // R6
            reset_clear_chk: assert property (@(posedge clk)
                !rst_n |-> (out_q == '0));
        end else begin : g_comb
            assign hours_o   = out_d.hours;
            assign minutes_o = out_d.minutes;
            assign seconds_o = out_d.seconds;
        end
    endgenerate

    // R1
    sec_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(secs_in) < int'(DAY_SECS)) |->
        ((int'(tot_min) * int'(DIVISOR) + int'(sec_rem) == int'(secs_in))
         && (int'(sec_rem) < int'(DIVISOR))));

    // R3
    min_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(secs_in) < int'(DAY_SECS)) |->
        ((int'(hrs) * int'(DIVISOR) + int'(min_rem) == int'(tot_min))
         && (int'(min_rem) < int'(DIVISOR))));

    // R4
    hours_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(secs_in) < int'(DAY_SECS)) |-> (int'(hrs) < 24));
endmodule

// File: tb/test_hms_split.sv
`timescale 1ns/1ps
module test_hms_split;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [16:0] secs_in;
    logic [4:0]  hours_o;
    logic [5:0]  minutes_o;
    logic [5:0]  seconds_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hms_split i_hms_split (
        .clk(clk), .rst_n(rst_n), .secs_in(secs_in),
        .hours_o(hours_o), .minutes_o(minutes_o), .seconds_o(seconds_o)
    );

    task automatic check_val(string req, int v);
        int eh, em, es;
        eh = v / 3600;
        em = (v / 60) % 60;
        es = v % 60;
        n_tests++;
        if (int'(hours_o) != eh || int'(minutes_o) != em || int'(seconds_o) != es) begin
            n_fail++;
            $display("FAIL %s in=%0d actual=%0d:%0d:%0d expected=%0d:%0d:%0d",
                     req, v, hours_o, minutes_o, seconds_o, eh, em, es);
        end
    endtask

    // R6: outputs are zero during reset
    task automatic test_reset();
        secs_in = 17'd12345;
        repeat (3) @(negedge clk);
        n_tests++;
        if (hours_o != 0 || minutes_o != 0 || seconds_o != 0) begin
            n_fail++;
            $display("FAIL R6 actual=%0d:%0d:%0d expected=0:0:0",
                     hours_o, minutes_o, seconds_o);
        end
        rst_n = 1'b1;
    endtask

    // R2 R3 R4: rollover and end-of-range values
    task automatic test_boundaries();
        int vals[12] = '{0, 59, 60, 61, 3599, 3600, 3661, 43199, 43200, 82800, 86340, 86399};
        foreach (vals[i]) begin
            @(negedge clk);
            secs_in = 17'(vals[i]);
            @(negedge clk);
            check_val("R2/R3/R4", vals[i]);
        end
    endtask

    // R5: one-cycle delay, outputs held between edges
    task automatic test_latency();
        @(negedge clk);
        secs_in = 17'd100;
        @(negedge clk);
        secs_in = 17'd7265;
        #2;
        check_val("R5 hold", 100);
        @(negedge clk);
        check_val("R5 update", 7265);
    endtask

    // R1: exhaustive sweep of the day
    task automatic test_sweep();
        @(negedge clk);
        secs_in = 17'd0;
        for (int v = 1; v <= 86400; v++) begin
            @(negedge clk);
            check_val("R1", v - 1);
            if (v < 86400) secs_in = 17'(v);
        end
    endtask

    initial begin
        rst_n   = 1'b0;
        secs_in = '0;
        test_reset();
        test_boundaries();
        test_latency();
        test_sweep();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule